// File: doc/BRIEF.md
# Sparse Page-Mapped Memory

This block answers loads and stores across a wide address window while holding only a few physical pages of storage. The address is cut into a page number and an offset within the page. A small table, searched in parallel, records which pool slot holds each page number. A page receives a slot only when a store of nonzero data reaches it and there is still room in the pool. Until that happens, loads from the page return zero and stores to it are dropped without any fault.

The block is meant for test environments that need something writable at arbitrary addresses. Such a space is mostly empty, so backing all of it would waste storage. A load to a page returns zeros for every byte that has not been stored since that page was bound. Slots are handed out in order and are never given back, except by reset. Reset clears every binding at once.

Top module: `sparse_page_mem`

## Requirements
- R1: The page number is `req_addr / PAGE_BYTES` and the offset is `req_addr % PAGE_BYTES`. All accesses to one page number use a single slot, so stores at several offsets of one page use up only one allocation.
- R2: A load from a page number with no slot returns all-zero data and does not allocate a slot.
- R3: A store to an unbound page allocates a slot only when both hold: at least one of its `req_size` low data bytes is nonzero, and (pages bound + 1) × PAGE_BYTES < NUM_SLOTS × PAGE_BYTES. With the defaults this means at most NUM_SLOTS−1 = 7 pages are ever bound.
- R4: A store to an unbound page that does not meet the R3 conditions is discarded. A later load from that page returns zero, and the store uses up no capacity.
- R5: A store that allocates is written into the new slot in the same access. Bytes of a bound page that have never been stored read as zero.
- R6: Data is little-endian: the byte at `req_addr + i` is `req_wdata[8*i +: 8]`. A load returns `req_size` bytes in the low lanes of `rsp_rdata`, and the unused upper lanes read zero.
- R7: An access is legal only when `req_size` is 1, 2, 4 or 8, the address is a multiple of `req_size`, and the access stays inside one page. An illegal access raises `rsp_err` for one cycle, does not raise `rsp_ready`, returns zero data and changes no stored byte.
- R8: A legal access raises `rsp_ready` for one cycle, on the clock edge after the one that samples `req_valid`. `rsp_rdata` is zero for stores. With `req_valid` low, neither `rsp_ready` nor `rsp_err` is raised.
- R9: Reset drives the response outputs to zero, unbinds every page and returns the full capacity. After reset, loads from previously written pages return zero, and NUM_SLOTS−1 new pages can be bound again.
- R10: A store to a page that is already bound is written even when its data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SZ_W | Access size in bytes |
| req_wdata | input | 8×DATA_BYTES | Store data, little-endian lanes |
| rsp_rdata | output | 8×DATA_BYTES | Load data, registered |
| rsp_ready | output | 1 | Legal access completed |
| rsp_err | output | 1 | Illegal access rejected |

## Verification
The hardest case to reach is the exhausted pool. In that state a nonzero store to a new page must be dropped, while stores to pages that are already bound still land. It only occurs after NUM_SLOTS−1 distinct pages have been bound. The directed sequence fills the pool page by page. The random phase draws addresses from a small set of page numbers, so the pool saturates many times between periodic resets. Stores whose only nonzero bytes lie above `req_size` check that the allocation test looks at the enabled lanes alone.

// File: rtl/spm_pkg.sv
package spm_pkg;

  // Power of two, nonzero, no wider than the data path.
  function automatic logic size_is_legal(input int unsigned sz, input int unsigned max_bytes);
    return (sz != 0) && ((sz & (sz - 1)) == 0) && (sz <= max_bytes);
  endfunction

endpackage

// File: rtl/spm_access_check.sv
module spm_access_check #(
  parameter int PAGE_BYTES = 256,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int SZ_W  = $clog2(DATA_BYTES) + 1
) (
  input  logic [OFF_W-1:0] off,
  input  logic [SZ_W-1:0]  size,
  output logic             ok
);

  logic             size_ok;
  logic             aligned;
  logic             in_page;
  logic [SZ_W-1:0]  size_m1;
  logic [OFF_W:0]   span;

  always_comb begin
    size_ok = spm_pkg::size_is_legal(int'(size), DATA_BYTES);
    size_m1 = size - 1'b1;
    aligned = ((off[SZ_W-1:0] & size_m1) == '0);
    span    = {1'b0, off} + (OFF_W+1)'(size);
    in_page = (span <= (OFF_W+1)'(PAGE_BYTES));
    ok      = size_ok && aligned && in_page;
  end

endmodule

// File: rtl/spm_tag_table.sv
module spm_tag_table #(
  parameter int NUM_SLOTS  = 8,
  parameter int PAGE_BYTES = 256,
  parameter int PN_W       = 24,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CAP_BYTES = NUM_SLOTS * PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PN_W-1:0]   lookup_pn,
  input  logic              alloc_en,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              can_alloc,
  output logic [SLOT_W-1:0] alloc_slot
);

  logic [NUM_SLOTS-1:0] bound_q, bound_d;
  logic [PN_W-1:0]      pn_q [NUM_SLOTS];
  logic [SLOT_W:0]      used_q, used_d;
  logic [NUM_SLOTS-1:0] match;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign match[g] = bound_q[g] && (pn_q[g] == lookup_pn);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (match[i]) hit_slot = SLOT_W'(i);
    end
  end

  assign hit        = |match;
  assign can_alloc  = ((int'(used_q) + 1) * PAGE_BYTES) < CAP_BYTES;
  assign alloc_slot = used_q[SLOT_W-1:0];

  always_comb begin
    bound_d = bound_q;
    used_d  = used_q;
    if (alloc_en) begin
      bound_d[alloc_slot] = 1'b1;
      used_d              = used_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q <= '0;
      used_q  <= '0;
    end else begin
      bound_q <= bound_d;
      used_q  <= used_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) pn_q[alloc_slot] <= lookup_pn;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R1
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used_q) <= NUM_SLOTS - 1); // R3
  AST_ALLOC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (can_alloc && !hit)); // R3

endmodule

// File: rtl/spm_page_store.sv
module spm_page_store #(
  parameter int NUM_SLOTS  = 8,
  parameter int PAGE_BYTES = 256,
  parameter int DATA_BYTES = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int SZ_W   = $clog2(DATA_BYTES) + 1,
  localparam int IDX_W  = SLOT_W + OFF_W,
  localparam int DEPTH  = NUM_SLOTS * PAGE_BYTES,
  localparam int DW     = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              clr_row,
  input  logic [SLOT_W-1:0] slot,
  input  logic [OFF_W-1:0]  off,
  input  logic [SZ_W-1:0]   size,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_data
);

  logic [7:0]            mem  [DEPTH];
  logic [PAGE_BYTES-1:0] bvld [NUM_SLOTS];
  logic [PAGE_BYTES-1:0] row_d;
  logic [DATA_BYTES-1:0] lane_en;
  logic [IDX_W-1:0]      base;

  assign base = {slot, off};

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++) lane_en[i] = (i < int'(size));
  end

  // Written-byte map: cleared when the slot is handed out, set per stored lane.
  always_comb begin
    row_d = clr_row ? '0 : bvld[slot];
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (lane_en[i]) row_d[OFF_W'(off + OFF_W'(i))] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) bvld[slot] <= row_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < DATA_BYTES; i++) begin
        if (lane_en[i]) mem[base + IDX_W'(i)] <= wdata[8*i +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      rd_data[8*i +: 8] = (lane_en[i] && bvld[slot][OFF_W'(off + OFF_W'(i))])
                          ? mem[base + IDX_W'(i)] : 8'h00;
    end
  end

endmodule

// File: rtl/sparse_page_mem.sv
module sparse_page_mem #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 256,
  parameter int NUM_SLOTS  = 8,
  parameter int DATA_BYTES = 8,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PN_W   = ADDR_W - OFF_W,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int SZ_W   = $clog2(DATA_BYTES) + 1,
  localparam int DW     = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_ready,
  output logic              rsp_err
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [OFF_W-1:0]  off;
  logic [PN_W-1:0]   pn;
  logic              chk_ok;
  logic              hit;
  logic              can_alloc;
  logic [SLOT_W-1:0] hit_slot;
  logic [SLOT_W-1:0] alloc_slot;
  logic [SLOT_W-1:0] slot;
  logic              data_nz;
  logic              alloc_en;
  logic              wr_en;
  logic [DW-1:0]     store_rd;
  logic [DW-1:0]     rdata_d;
  logic              ready_d;
  logic              err_d;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign off = req_addr[OFF_W-1:0];
  assign pn  = req_addr[ADDR_W-1:OFF_W];

  spm_access_check #(.PAGE_BYTES(PAGE_BYTES), .DATA_BYTES(DATA_BYTES)) u_check (
    .off  (off),
    .size (req_size),
    .ok   (chk_ok)
  );

  spm_tag_table #(.NUM_SLOTS(NUM_SLOTS), .PAGE_BYTES(PAGE_BYTES), .PN_W(PN_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookup_pn  (pn),
    .alloc_en   (alloc_en),
    .hit        (hit),
    .hit_slot   (hit_slot),
    .can_alloc  (can_alloc),
    .alloc_slot (alloc_slot)
  );

  // Only lanes inside the access size count toward "nonzero data".
  always_comb begin
    data_nz = 1'b0;
    for (int i = 0; i < DATA_BYTES; i++) begin
      if ((i < int'(req_size)) && (req_wdata[8*i +: 8] != 8'h00)) data_nz = 1'b1;
    end
  end

  assign alloc_en = req_valid && req_we && chk_ok && !hit && data_nz && can_alloc;
  assign wr_en    = req_valid && req_we && chk_ok && (hit || alloc_en);
  assign slot     = hit ? hit_slot : alloc_slot;

  spm_page_store #(.NUM_SLOTS(NUM_SLOTS), .PAGE_BYTES(PAGE_BYTES), .DATA_BYTES(DATA_BYTES)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .clr_row (alloc_en),
    .slot    (slot),
    .off     (off),
    .size    (req_size),
    .wdata   (req_wdata),
    .rd_data (store_rd)
  );

  always_comb begin
    ready_d = req_valid && chk_ok;
    err_d   = req_valid && !chk_ok;
    rdata_d = (req_valid && !req_we && chk_ok && hit) ? store_rd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= ready_d;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && rsp_err)); // R7
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0)); // R7
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_ready || rsp_err)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_ready && !rsp_err)); // R8
  AST_UNBACKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && chk_ok && !hit) |=> (rsp_rdata == '0)); // R2
  AST_STORE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (rsp_rdata == '0)); // R8

endmodule

// File: tb/sparse_page_mem_test.sv
module sparse_page_mem_test;

  localparam int CLK_PERIOD = 10;
  localparam int PB = 256;
  localparam int NS = 8;

  logic        clk;
  logic        rst_ni;
  logic        req_valid;
  logic        req_we;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic [63:0] req_wdata;
  logic [63:0] rsp_rdata;
  logic        rsp_ready;
  logic        rsp_err;

  int n_run  = 0;
  int n_fail = 0;

  // Reference model
  logic [23:0] m_pn  [NS];
  bit          m_vld [NS];
  int          m_used;
  logic [7:0]  m_mem [NS*PB];
  bit          m_bv  [NS*PB];

  sparse_page_mem uut (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_ready (rsp_ready),
    .rsp_err   (rsp_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int m_find(input logic [23:0] pn);
    for (int s = 0; s < NS; s++) if (m_vld[s] && m_pn[s] == pn) return s;
    return -1;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < NS; s++) m_vld[s] = 1'b0;
    m_used = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual {ready,err,rdata}=%h expected %h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge after checking.
  task automatic access(input bit we, input logic [31:0] addr, input int sz,
                        input logic [63:0] data, input string req);
    bit          legal;
    bit          nz;
    int          slot;
    logic [63:0] exp_rd;
    logic [65:0] exp_v;
    logic [65:0] act_v;
    legal  = (sz == 1 || sz == 2 || sz == 4 || sz == 8) && (addr % sz == 0);
    exp_rd = '0;
    slot   = m_find(addr[31:8]);
    if (legal) begin
      if (!we) begin
        if (slot >= 0) begin
          for (int i = 0; i < sz; i++) begin
            int idx = slot*PB + int'(addr[7:0]) + i;
            if (m_bv[idx]) exp_rd[8*i +: 8] = m_mem[idx];
          end
        end
      end else begin
        nz = 1'b0;
        for (int i = 0; i < sz; i++) if (data[8*i +: 8] != 8'h00) nz = 1'b1;
        if (slot < 0 && nz && (m_used + 1) * PB < NS * PB) begin
          slot = m_used;
          m_vld[slot] = 1'b1;
          m_pn[slot]  = addr[31:8];
          m_used++;
          for (int j = 0; j < PB; j++) m_bv[slot*PB + j] = 1'b0;
        end
        if (slot >= 0) begin
          for (int i = 0; i < sz; i++) begin
            int idx = slot*PB + int'(addr[7:0]) + i;
            m_mem[idx] = data[8*i +: 8];
            m_bv[idx]  = 1'b1;
          end
        end
      end
    end
    exp_v     = {legal, !legal, exp_rd};
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = addr;
    req_size  = 4'(sz);
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    act_v = {rsp_ready, rsp_err, rsp_rdata};
    check(act_v === exp_v, req, act_v, exp_v);
  endtask

  task automatic do_reset(input string req);
    logic [65:0] act_v;
    req_valid = 1'b0;
    rst_ni    = 1'b0;
    repeat (3) @(negedge clk);
    act_v = {rsp_ready, rsp_err, rsp_rdata};
    check(act_v === '0, req, act_v, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    m_clear();
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] pages [10];
    void'($urandom(32'd20240611));
    pages = '{24'h000001, 24'h000002, 24'h000003, 24'h000010, 24'h000100,
              24'h00FFFF, 24'h0ABCDE, 24'hFFFFFF, 24'h000055, 24'h123456};
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    m_clear();
    @(negedge clk);
    do_reset("R9");

    // R2: unbound load
    access(0, 32'h1234_5600, 8, '0, "R2");
    // R3/R4: zero store does not allocate, load stays zero
    access(1, 32'h0000_0100, 4, 64'h0, "R3");
    access(0, 32'h0000_0100, 4, '0, "R4");
    // R3: only nonzero bytes above size -> still zero data
    access(1, 32'h0000_0100, 1, 64'hFF00_0000_0000_0000, "R3");
    access(0, 32'h0000_0100, 8, '0, "R4");
    // R6: little-endian packing
    access(1, 32'h0000_0100, 8, 64'h1122_3344_5566_7788, "R6");
    access(0, 32'h0000_0103, 1, '0, "R6");
    access(0, 32'h0000_0106, 2, '0, "R6");
    access(0, 32'h0000_0100, 8, '0, "R6");
    // R5: unwritten bytes of a bound page are zero
    access(0, 32'h0000_0108, 8, '0, "R5");
    access(1, 32'h0000_010A, 1, 64'hAB, "R5");
    access(0, 32'h0000_0108, 4, '0, "R5");
    // R1: another offset in the same page, then six more pages fill the pool
    access(1, 32'h0000_01F8, 8, 64'hDEAD_BEEF_0000_0001, "R1");
    for (int p = 2; p < 8; p++) access(1, {8'h00, 16'(p), 8'h40}, 4, 64'(32'hC0DE_0000 + p), "R3");
    for (int p = 2; p < 8; p++) access(0, {8'h00, 16'(p), 8'h40}, 4, '0, "R1");
    access(0, 32'h0000_01F8, 8, '0, "R1");
    // R3/R4: pool exhausted, eighth page dropped
    access(1, 32'h0000_0900, 8, 64'h1, "R3");
    access(0, 32'h0000_0900, 8, '0, "R4");
    // R10: zero store to bound page lands
    access(1, 32'h0000_0100, 2, 64'h0, "R10");
    access(0, 32'h0000_0100, 8, '0, "R10");
    // R7: illegal accesses, no side effect
    access(0, 32'h0000_0101, 2, '0, "R7");
    access(1, 32'h0000_0100, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    access(1, 32'h0000_0104, 0, 64'hFF, "R7");
    access(0, 32'h0000_0100, 9, '0, "R7");
    access(1, 32'h0000_01FC, 8, 64'h77, "R7");
    access(0, 32'h0000_0100, 8, '0, "R7");
    // R8: idle cycle produces no response
    @(negedge clk);
    check({rsp_ready, rsp_err} === 2'b00, "R8", {64'h0, rsp_ready, rsp_err}, '0);
    // R9: reset unbinds and restores capacity
    do_reset("R9");
    access(0, 32'h0000_0100, 8, '0, "R9");
    for (int p = 16; p < 23; p++) access(1, {8'h00, 16'(p), 8'h00}, 8, 64'(p), "R9");
    for (int p = 16; p < 23; p++) access(0, {8'h00, 16'(p), 8'h00}, 8, '0, "R9");

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      int          sz;
      int          r;
      bit          we;
      logic [7:0]  off;
      logic [63:0] data;
      string       tag;
      if (n % 1500 == 1499) do_reset("R9");
      r = int'($urandom % 100);
      if (r < 90) sz = 1 << ($urandom % 4);
      else        sz = int'($urandom % 16) | 1;
      off = 8'($urandom);
      if ($urandom % 100 < 85 && sz > 0) off = off & ~8'(sz - 1);
      we = ($urandom % 2) == 1;
      r  = int'($urandom % 4);
      if (r == 0)      data = '0;
      else if (r == 1) data = 64'(8'($urandom)) << (8 * ($urandom % 8));
      else             data = {$urandom, $urandom};
      if (!((sz == 1 || sz == 2 || sz == 4 || sz == 8) && (off % sz == 0))) tag = "R7";
      else if (we)     tag = "R5";
      else             tag = "R6";
      access(we, {pages[$urandom % 10], off}, sz, data, tag);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule